// File: doc/BRIEF.md
# Programmable PRBS and Repetitive Pattern Generator

This block produces the serial stimulus for a bit-error-rate tester. A single 32-bit shift register serves three kinds of pattern. It runs pseudorandom sequences from a two-tap polynomial x^n + x^y + 1. It repeats a word of n bits. It also runs a quasi-random mode that suppresses long runs of zeros. The tap position and the register length are programmable, so software can pick the pattern without any change to the hardware.

A 32-bit seed is copied into the register on the rising edge of a load control input. After that, each cycle with the bit-enable input high advances the register by one position and presents one new pattern bit on the registered serial output. Cycles with bit-enable low hold the output and the register unchanged. The surrounding tester decides which bit slots carry pattern data and drives bit-enable accordingly.

Top module: `pattern_gen`

## Requirements
- R1: Register position k (1..32) is bit k-1 of the state. On a shift, every position k moves to k+1, and the new feedback value enters position 1.
- R2: With `pat_repeat`=0 and `qrss_en`=0 (PRBS), the feedback is the XOR of position n and position y. Here n = `len_sel`+1 and y = `tap_sel`+1.
- R3: With `pat_repeat`=1 and `qrss_en`=0 (repetitive), the feedback is position n alone. After a load, the output then repeats the seed's low n bits, starting at seed bit n-1 and ending at bit 0.
- R4: On each shift, `dout` takes the feedback value computed from the register before that shift, unless R6 forces it to 1.
- R5: `qrss_en`=1 selects the quasi-random mode whatever `pat_repeat` is. In this mode the feedback is the XOR of positions 17 and 20.
- R6: In quasi-random mode, a shift drives `dout` to 1 when positions 1 through 14 are all zero. As a result the output never carries more than 14 zeros in a row.
- R7: In PRBS and quasi-random modes, the feedback is forced to 1 when positions 1 through 31 are all zero. In repetitive mode no such forcing applies.
- R8: A rising edge on `load` copies `seed` into the register on that clock. Holding `load` high does not load again.
- R9: A load takes priority over a shift in the same cycle. That cycle does not shift, and `dout` holds its value.
- R10: When `bit_en` is low and no load occurs, both the register and `dout` keep their values.
- R11: A synchronous active-high `rst` clears the register, `dout` and the load-edge history to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_repeat | input | 1 | 1 = repetitive word, 0 = PRBS |
| qrss_en | input | 1 | 1 = quasi-random mode (overrides pat_repeat) |
| tap_sel | input | 5 | Second tap position minus one (y-1) |
| len_sel | input | 5 | Length / first tap position minus one (n-1) |
| seed | input | 32 | Value loaded into the register |
| load | input | 1 | Load control; its rising edge loads the seed |
| bit_en | input | 1 | Advance the pattern by one bit this cycle |
| dout | output | 1 | Registered serial pattern bit |

## Verification
A load edge and a shift request can land on the same clock. The bench provokes this by raising `load` and `bit_en` on the same falling edge. It judges the result in two ways. `dout` must be unchanged after that clock. The following bits must then come out as the seed's sequence, not as a sequence that shifted once before the load took effect. In the same way, the bench holds `load` high across several shift cycles to confirm that only the first of them reloads.

// File: rtl/patgen_pkg.sv
package patgen_pkg;
  localparam int REG_W     = 32;
  localparam int FIELD_W   = 5;
  localparam int QRSS_TA   = 17;
  localparam int QRSS_TB   = 20;
  localparam int ZERO_RUN  = 14;

  typedef enum logic [1:0] {
    MODE_PRBS = 2'd0,
    MODE_REP  = 2'd1,
    MODE_QRSS = 2'd2
  } pat_mode_e;
endpackage

// File: rtl/pat_mode_dec.sv
module pat_mode_dec
  import patgen_pkg::*;
(
  input  logic      pat_repeat,
  input  logic      qrss_en,
  output pat_mode_e mode
);
  always_comb begin
    if (qrss_en)         mode = MODE_QRSS;
    else if (pat_repeat) mode = MODE_REP;
    else                 mode = MODE_PRBS;
  end
endmodule

// File: rtl/pat_load_edge.sv
module pat_load_edge (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic load_pulse
);
  logic load_q;

  always_ff @(posedge clk) begin
    if (rst) load_q <= 1'b0;
    else     load_q <= load;
  end

  assign load_pulse = load & ~load_q;
endmodule

// File: rtl/pat_feedback.sv
module pat_feedback
  import patgen_pkg::*;
#(
  parameter int W       = 32,
  parameter int FW      = 5,
  parameter int TAP_A   = 17,
  parameter int TAP_B   = 20,
  parameter int ZRUN    = 14
) (
  input  logic [W-1:0]  sr,
  input  pat_mode_e     mode,
  input  logic [FW-1:0] tap_sel,
  input  logic [FW-1:0] len_sel,
  output logic          fb,
  output logic          out_bit
);
  logic tap_n, tap_y, raw_fb, lock_guard, zero_run;

  assign tap_n = sr[len_sel];
  assign tap_y = sr[tap_sel];

  always_comb begin
    case (mode)
      MODE_REP:  raw_fb = tap_n;
      MODE_QRSS: raw_fb = sr[TAP_A-1] ^ sr[TAP_B-1];
      default:   raw_fb = tap_n ^ tap_y;
    endcase
  end

  // no lockup on an all-zero register in the polynomial modes
  assign lock_guard = (mode != MODE_REP) && (sr[W-2:0] == '0);
  assign fb         = raw_fb | lock_guard;

  // zero-run suppression in quasi-random mode
  assign zero_run = (mode == MODE_QRSS) && (sr[ZRUN-1:0] == '0);
  assign out_bit  = fb | zero_run;
endmodule

// File: rtl/pat_shift_reg.sv
module pat_shift_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_pulse,
  input  logic         bit_en,
  input  logic [W-1:0] seed,
  input  logic         fb,
  input  logic         out_bit,
  output logic [W-1:0] sr,
  output logic         dout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      dout <= 1'b0;
    end else if (load_pulse) begin
      sr   <= seed;
    end else if (bit_en) begin
      sr   <= {sr[W-2:0], fb};
      dout <= out_bit;
    end
  end
endmodule

// File: rtl/pattern_gen.sv
module pattern_gen
  import patgen_pkg::*;
#(
  parameter int W     = REG_W,
  parameter int FW    = FIELD_W,
  parameter int TAP_A = QRSS_TA,
  parameter int TAP_B = QRSS_TB,
  parameter int ZRUN  = ZERO_RUN
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pat_repeat,
  input  logic          qrss_en,
  input  logic [FW-1:0] tap_sel,
  input  logic [FW-1:0] len_sel,
  input  logic [W-1:0]  seed,
  input  logic          load,
  input  logic          bit_en,
  output logic          dout
);
  pat_mode_e   mode;
  logic        load_pulse;
  logic        fb, out_bit;
  logic [W-1:0] sr;

  pat_mode_dec u_mode (
    .pat_repeat (pat_repeat),
    .qrss_en    (qrss_en),
    .mode       (mode)
  );

  pat_load_edge u_edge (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .load_pulse (load_pulse)
  );

  pat_feedback #(
    .W(W), .FW(FW), .TAP_A(TAP_A), .TAP_B(TAP_B), .ZRUN(ZRUN)
  ) u_fb (
    .sr      (sr),
    .mode    (mode),
    .tap_sel (tap_sel),
    .len_sel (len_sel),
    .fb      (fb),
    .out_bit (out_bit)
  );

  pat_shift_reg #(.W(W)) u_sr (
    .clk        (clk),
    .rst        (rst),
    .load_pulse (load_pulse),
    .bit_en     (bit_en),
    .seed       (seed),
    .fb         (fb),
    .out_bit    (out_bit),
    .sr         (sr),
    .dout       (dout)
  );
endmodule

// File: rtl/pattern_gen_chk.sv
module pattern_gen_chk
  import patgen_pkg::*;
#(
  parameter int W    = 32,
  parameter int FW   = 5,
  parameter int ZRUN = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          bit_en,
  input logic          load_pulse,
  input pat_mode_e     mode,
  input logic [FW-1:0] len_sel,
  input logic [W-1:0]  seed,
  input logic [W-1:0]  sr,
  input logic          dout
);
  AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !load_pulse) |=> (sr[W-1:1] == $past(sr[W-2:0]))); // R1

  AST_REP_OUT: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !load_pulse && mode == MODE_REP) |=> (dout == $past(sr[len_sel]))); // R3

  AST_ZERO_RUN: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !load_pulse && mode == MODE_QRSS && sr[ZRUN-1:0] == '0) |=> dout); // R6

  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    (bit_en && !load_pulse && mode != MODE_REP && sr[W-2:0] == '0) |=> (dout && sr[0])); // R7

  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> (sr == $past(seed))); // R8

  AST_LOAD_HOLDS_OUT: assert property (@(posedge clk) disable iff (rst)
    load_pulse |=> $stable(dout)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bit_en && !load_pulse) |=> ($stable(dout) && $stable(sr))); // R10
endmodule

bind pattern_gen pattern_gen_chk #(.W(W), .FW(FW), .ZRUN(ZRUN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_en     (bit_en),
  .load_pulse (load_pulse),
  .mode       (mode),
  .len_sel    (len_sel),
  .seed       (seed),
  .sr         (sr),
  .dout       (dout)
);

// File: tb/tb_pattern_gen.sv
`timescale 1ns/1ps
module tb_pattern_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pat_repeat = 1'b0;
  logic        qrss_en = 1'b0;
  logic [4:0]  tap_sel = '0;
  logic [4:0]  len_sel = '0;
  logic [31:0] seed = '0;
  logic        load = 1'b0;
  logic        bit_en = 1'b0;
  logic        dout;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] m;   // bench model state

  always #4 clk = ~clk;  // 125 MHz

  pattern_gen dut (
    .clk(clk), .rst(rst), .pat_repeat(pat_repeat), .qrss_en(qrss_en),
    .tap_sel(tap_sel), .len_sel(len_sel), .seed(seed), .load(load),
    .bit_en(bit_en), .dout(dout)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout=%b expected=%b (t=%0t)", req, act, exp, $time);
    end
  endtask

  // returns {output bit, next state}
  function automatic logic [32:0] mstep(input logic [31:0] s);
    logic f, o;
    int n, y;
    n = int'(len_sel) + 1;
    y = int'(tap_sel) + 1;
    if (qrss_en)         f = s[16] ^ s[19];
    else if (pat_repeat) f = s[n-1];
    else                 f = s[n-1] ^ s[y-1];
    if ((qrss_en || !pat_repeat) && s[30:0] == 31'd0) f = 1'b1;
    o = f;
    if (qrss_en && s[13:0] == 14'd0) o = 1'b1;
    return {o, s[30:0], f};
  endfunction

  task automatic shift_raw();
    bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
  endtask

  task automatic shift_chk(input string req);
    logic [32:0] r;
    r = mstep(m);
    shift_raw();
    m = r[31:0];
    chk(req, dout, r[32]);
  endtask

  task automatic do_load(input logic [31:0] v);
    seed = v;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    @(negedge clk);
    m = v;
  endtask

  task automatic set_cfg(input logic rep, input logic q, input int n, input int y);
    pat_repeat = rep;
    qrss_en    = q;
    len_sel    = 5'(n - 1);
    tap_sel    = 5'(y - 1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected<=%0d", cyc, 200000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic prev, held;
    logic [39:0] first;
    int run, maxrun;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset", dout, 1'b0);

    // R3 repetitive sweep: n = 1..8 and 32, expected bit = seed[n-1-(k mod n)]
    for (int n = 1; n <= 9; n++) begin
      int nn;
      logic [31:0] sv;
      nn = (n == 9) ? 32 : n;
      sv = 32'hA5C3_96E1 ^ (32'h1111_1111 * n);
      set_cfg(1'b1, 1'b0, nn, 1);
      do_load(sv);
      for (int k = 0; k < 2*nn + 3; k++) begin
        shift_raw();
        chk("R3 repeat word", dout, sv[nn - 1 - (k % nn)]);
      end
    end

    // R3/R7 example: 1-in-8 word, and zero seed stays zero in repetitive mode
    set_cfg(1'b1, 1'b0, 8, 1);
    do_load(32'hFFFF_FF01);
    for (int k = 0; k < 16; k++) begin
      shift_raw();
      chk("R3 one-in-eight", dout, (k % 8) == 7);
    end
    do_load(32'h0);
    for (int k = 0; k < 6; k++) begin
      shift_raw();
      chk("R7 no guard in repetitive", dout, 1'b0);
    end

    // R1/R2/R4 PRBS sweep over small n, all y < n
    for (int n = 2; n <= 7; n++)
      for (int y = 1; y < n; y++) begin
        set_cfg(1'b0, 1'b0, n, y);
        do_load(32'h0000_0001 + 32'(n*7 + y));
        for (int k = 0; k < 40; k++) shift_chk("R2 prbs sweep");
      end

    // R2 period: x^15 + x^14 + 1 repeats every 32767 bits
    set_cfg(1'b0, 1'b0, 15, 14);
    do_load(32'h0000_0001);
    for (int k = 0; k < 40; k++) begin
      shift_raw();
      first[k] = dout;
    end
    for (int k = 40; k < 32767; k++) shift_raw();
    for (int k = 0; k < 40; k++) begin
      shift_raw();
      chk("R2 period 32767", dout, first[k]);
    end

    // R7 lockup guard in PRBS
    set_cfg(1'b0, 1'b0, 5, 3);
    do_load(32'h0);
    shift_chk("R7 prbs lockup guard");
    chk("R7 guard drives one", dout, 1'b1);
    for (int k = 0; k < 10; k++) shift_chk("R7 after guard");

    // R10 hold: bit_en low keeps output and state
    held = dout;
    repeat (6) @(negedge clk);
    chk("R10 hold output", dout, held);
    for (int k = 0; k < 8; k++) shift_chk("R10 state kept");

    // R9 load and shift in the same cycle
    set_cfg(1'b1, 1'b0, 6, 1);
    prev = dout;
    seed = 32'h0000_002D;   // 101101
    load = 1'b1;
    bit_en = 1'b1;
    @(negedge clk);
    chk("R9 load beats shift, output held", dout, prev);
    // R8 load held high: shifts continue, no reload
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 level load no reload", dout, seed[5 - k]);
    end
    load = 1'b0;
    bit_en = 1'b0;
    @(negedge clk);
    for (int k = 3; k < 9; k++) begin
      shift_raw();
      chk("R8 sequence continues", dout, seed[5 - (k % 6)]);
    end

    // R5/R6 quasi-random mode, pat_repeat set to show the override
    set_cfg(1'b1, 1'b1, 1, 1);
    do_load(32'h0000_C000);
    shift_chk("R6 forced one on zero run");
    chk("R6 first bit is one", dout, 1'b1);
    do_load(32'h0);
    shift_chk("R7 qrss lockup guard");
    do_load(32'h1234_5678);
    run = 0;
    maxrun = 0;
    for (int k = 0; k < 3000; k++) begin
      shift_chk("R5 qrss sequence");
      run = dout ? 0 : run + 1;
      if (run > maxrun) maxrun = run;
    end
    checks++;
    if (maxrun > 14) begin
      errors++;
      $display("FAIL R6 zero run: max=%0d expected<=%0d", maxrun, 14);
    end

    // R11 reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 reset clears output", dout, 1'b0);
    m = 32'h0;
    set_cfg(1'b1, 1'b0, 4, 1);
    shift_chk("R11 state cleared");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule